// File: doc/BRIEF.md
# Cache Maintenance Operation Sequencer

This block sits between the core's coprocessor register port and the memory-side maintenance machinery. It accepts one request at a time, each made of a 4-bit CRm selector, a 3-bit opcode2 selector, a 32-bit operand, a read/write flag and the requesting instruction's address. It decodes the request into a command for the instruction cache, the data cache, or both. It also works out what the operand means: a line address, a set/way index, or nothing.

Cache commands leave as one-cycle strobes, together with a kind code and the processed operand. The block then holds `busy` until every addressed cache has answered with a done pulse. Two further operations involve the write buffer. The barrier holds the core until the write buffer reports empty. The sleep sequence drains the write buffer first, then raises a low-power request until an interrupt or a debug request arrives. The two test-and-clean reads return a status word with a single "data cache fully clean" flag.

The caches, the write buffer and the core are outside the block. `busy` is the core's stall signal.

Top module: `cache_maint_sequencer`

## Requirements
- R1: During and right after reset, `busy`, `ic_cmd_valid`, `dc_cmd_valid`, `wb_drain_req`, `lowpower_req`, `rd_valid`, `wake_valid` and `undef_op` are all low.
- R2: A write with CRm=7, opcode2=0 strobes both caches in the same cycle, each with kind 0 (invalidate all) and a zero operand. `busy` stays high until both done pulses have been seen, in either order.
- R3: Instruction-cache writes produce `ic_cmd_kind` codes as follows: CRm=5/op2=0 gives 0 (all), CRm=5/op2=1 gives 1 (by address), CRm=5/op2=2 gives 2 (by set/way), and CRm=13/op2=1 gives 3 (prefetch line by address).
- R4: Data-cache writes produce `dc_cmd_kind` codes as follows. CRm=6 gives 0 (op2=0, invalidate all) or 1 (invalidate entry). CRm=10 gives 2 (clean entry). CRm=14 gives 3 (clean and invalidate entry). For the entry operations, op2=1 selects by address and op2=2 selects by set/way.
- R5: For address operands, `op_sw`=0 and `op_addr` is the operand with its low 5 bits cleared. For set/way operands, `op_sw`=1, `op_way` is bits [31:30] and `op_set` is bits [10:5]; every other operand bit has no effect. These values assume the defaults of 4 ways, 32-byte lines and 64 sets.
- R6: A command strobe lasts exactly one cycle, starting the cycle after the request is accepted. `busy` rises in that same cycle and falls in the cycle after the last required done pulse. A request presented while `busy` is high is ignored.
- R7: A read with CRm=10/op2=3 strobes the data cache with kind 4; a read with CRm=14/op2=3 strobes it with kind 5. When `dc_done` arrives, `rd_valid` pulses with `rd_data` bit 30 equal to `dc_all_clean` and all other bits zero.
- R8: A write with CRm=10/op2=4 raises `wb_drain_req` and `busy`. Both stay high until `wb_empty` is seen, and no cache is strobed.
- R9: A write with CRm=0/op2=4 first drains the write buffer as in R8. `lowpower_req` rises only after `wb_empty` is seen and stays high, together with `busy`, until `irq` or `dbg_req`.
- R10: Waking from sleep by `irq` pulses `wake_valid` with `wake_link` = request address + 8. Waking by `dbg_req` alone ends the sequence without `wake_valid`.
- R11: Any other CRm/op2/direction combination pulses `undef_op` for one cycle. It issues no strobe and leaves `busy` low. This includes reads of write-only encodings and writes with op2=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_crm | input | 4 | CRm selector |
| req_op2 | input | 3 | opcode2 selector |
| req_data | input | 32 | Operand |
| req_pc | input | 32 | Address of the requesting instruction |
| busy | output | 1 | Core stall: an operation is in flight |
| undef_op | output | 1 | One-cycle pulse: request not recognised |
| rd_valid | output | 1 | One-cycle pulse: read result on `rd_data` |
| rd_data | output | 32 | Test-and-clean status word |
| ic_cmd_valid | output | 1 | Instruction-cache command strobe |
| ic_cmd_kind | output | 2 | Instruction-cache command code |
| ic_done | input | 1 | Instruction-cache completion pulse |
| dc_cmd_valid | output | 1 | Data-cache command strobe |
| dc_cmd_kind | output | 3 | Data-cache command code |
| dc_done | input | 1 | Data-cache completion pulse |
| dc_all_clean | input | 1 | Data cache holds no dirty line (valid with `dc_done`) |
| op_sw | output | 1 | Operand is a set/way index |
| op_addr | output | 32 | Line-aligned address operand |
| op_set | output | 6 | Set index |
| op_way | output | 2 | Way index |
| wb_drain_req | output | 1 | Request to empty the write buffer |
| wb_empty | input | 1 | Write buffer is empty |
| lowpower_req | output | 1 | Low-power state request |
| irq | input | 1 | Interrupt wake-up |
| dbg_req | input | 1 | Debug wake-up |
| wake_valid | output | 1 | One-cycle pulse: woken by interrupt |
| wake_link | output | 32 | Return link for the interrupt handler |

## Verification
The decoder is tried with every legal CRm/opcode2 pair in both directions, and with illegal pairs that sit next to legal ones (opcode2=3 written, write-only codes read, an unused CRm). This separates a correct decode from one that checks only CRm or ignores the direction. The done latencies of the two caches are varied and swapped on the dual invalidate, which exposes a sequencer that waits on only one side. A second request sent during a long operation shows whether `busy` really blocks acceptance. Set/way operands with every bit set, and addresses with low offset bits set, show whether the field slicing is right. The sleep sequence is run with a slow drain, then with wake-up by interrupt and by debug, which separates drain-before-sleep ordering and the return-link rule.

// File: rtl/cmo_pkg.sv
package cmo_pkg;

   typedef enum logic [1:0] {
      IC_INV_ALL  = 2'd0,
      IC_INV_MVA  = 2'd1,
      IC_INV_SW   = 2'd2,
      IC_PREFETCH = 2'd3
   } ic_kind_e;

   typedef enum logic [2:0] {
      DC_INV_ALL        = 3'd0,
      DC_INV_ENTRY      = 3'd1,
      DC_CLEAN          = 3'd2,
      DC_CLEAN_INV      = 3'd3,
      DC_TEST_CLEAN     = 3'd4,
      DC_TEST_CLEAN_INV = 3'd5
   } dc_kind_e;

   typedef enum logic [1:0] {
      OPND_NONE = 2'd0,
      OPND_MVA  = 2'd1,
      OPND_SW   = 2'd2
   } opnd_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_CACHE = 2'd1,
      ST_DRAIN = 2'd2,
      ST_SLEEP = 2'd3
   } cmo_state_e;

   typedef struct packed {
      logic     legal;
      logic     use_ic;
      logic     use_dc;
      ic_kind_e ic_kind;
      dc_kind_e dc_kind;
      opnd_e    opnd;
      logic     is_read;
      logic     is_drain;
      logic     is_wfi;
   } cmo_dec_t;

   localparam logic [3:0] SEL_SLEEP = 4'd0;
   localparam logic [3:0] SEL_IC    = 4'd5;
   localparam logic [3:0] SEL_DC    = 4'd6;
   localparam logic [3:0] SEL_BOTH  = 4'd7;
   localparam logic [3:0] SEL_CLEAN = 4'd10;
   localparam logic [3:0] SEL_PREF  = 4'd13;
   localparam logic [3:0] SEL_CLINV = 4'd14;

endpackage

// File: rtl/cmo_decode.sv
module cmo_decode
   import cmo_pkg::*;
(
   input  logic       write,
   input  logic [3:0] crm,
   input  logic [2:0] op2,
   output cmo_dec_t   dec
);

   // entry-select variants shared by several data-cache operations
   function automatic cmo_dec_t dc_entry(input dc_kind_e k, input logic [2:0] o, input logic w);
      cmo_dec_t r;
      r = '0;
      if (w && (o == 3'd1 || o == 3'd2)) begin
         r.legal   = 1'b1;
         r.use_dc  = 1'b1;
         r.dc_kind = k;
         r.opnd    = (o == 3'd1) ? OPND_MVA : OPND_SW;
      end
      return r;
   endfunction

   // test-and-clean style reads
   function automatic cmo_dec_t dc_test(input dc_kind_e k, input logic w);
      cmo_dec_t r;
      r = '0;
      if (!w) begin
         r.legal   = 1'b1;
         r.use_dc  = 1'b1;
         r.dc_kind = k;
         r.opnd    = OPND_NONE;
         r.is_read = 1'b1;
      end
      return r;
   endfunction

   always_comb begin
      dec = '0;
      unique case (crm)
         SEL_BOTH: begin
            if (write && op2 == 3'd0) begin
               dec.legal   = 1'b1;
               dec.use_ic  = 1'b1;
               dec.use_dc  = 1'b1;
               dec.ic_kind = IC_INV_ALL;
               dec.dc_kind = DC_INV_ALL;
            end
         end
         SEL_IC: begin
            if (write && op2 <= 3'd2) begin
               dec.legal  = 1'b1;
               dec.use_ic = 1'b1;
               unique case (op2)
                  3'd0:    dec.ic_kind = IC_INV_ALL;
                  3'd1:    begin dec.ic_kind = IC_INV_MVA; dec.opnd = OPND_MVA; end
                  default: begin dec.ic_kind = IC_INV_SW;  dec.opnd = OPND_SW;  end
               endcase
            end
         end
         SEL_PREF: begin
            if (write && op2 == 3'd1) begin
               dec.legal   = 1'b1;
               dec.use_ic  = 1'b1;
               dec.ic_kind = IC_PREFETCH;
               dec.opnd    = OPND_MVA;
            end
         end
         SEL_DC: begin
            if (write && op2 == 3'd0) begin
               dec.legal   = 1'b1;
               dec.use_dc  = 1'b1;
               dec.dc_kind = DC_INV_ALL;
            end else begin
               dec = dc_entry(DC_INV_ENTRY, op2, write);
            end
         end
         SEL_CLEAN: begin
            if (op2 == 3'd3)                dec = dc_test(DC_TEST_CLEAN, write);
            else if (op2 == 3'd4 && write)  begin dec.legal = 1'b1; dec.is_drain = 1'b1; end
            else                            dec = dc_entry(DC_CLEAN, op2, write);
         end
         SEL_CLINV: begin
            if (op2 == 3'd3) dec = dc_test(DC_TEST_CLEAN_INV, write);
            else             dec = dc_entry(DC_CLEAN_INV, op2, write);
         end
         SEL_SLEEP: begin
            if (write && op2 == 3'd4) begin
               dec.legal  = 1'b1;
               dec.is_wfi = 1'b1;
            end
         end
         default: dec = '0;
      endcase
   end

endmodule

// File: rtl/cmo_operand.sv
module cmo_operand
   import cmo_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_WAYS   = 4,
   parameter int LINE_BYTES = 32,
   parameter int NUM_SETS   = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
   localparam int WAY_W     = $clog2(NUM_WAYS),
   localparam int WAY_WP    = (WAY_W > 0) ? WAY_W : 1
) (
   input  logic [DATA_W-1:0] data,
   input  opnd_e             kind,
   output logic              sw,
   output logic [DATA_W-1:0] addr,
   output logic [SET_W-1:0]  set_idx,
   output logic [WAY_WP-1:0] way_idx
);

   if (NUM_WAYS < 1 || (NUM_WAYS & (NUM_WAYS - 1)) != 0) begin : g_bad_ways
      $error("NUM_WAYS must be a power of two");
   end
   if (LINE_BYTES < 4 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 4");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two of at least 2");
   end
   if (OFF_W + SET_W + WAY_W > DATA_W) begin : g_bad_fit
      $error("set/way fields do not fit the operand");
   end

   logic [DATA_W-1:0] line_mask;
   logic [SET_W-1:0]  set_raw;
   logic [WAY_WP-1:0] way_raw;

   assign line_mask = {DATA_W{1'b1}} << OFF_W;
   assign set_raw   = data[OFF_W +: SET_W];

   if (WAY_W > 0) begin : g_way_field
      assign way_raw = data[DATA_W-1 -: WAY_W];
   end else begin : g_way_direct
      assign way_raw = '0;
   end

   always_comb begin
      sw      = (kind == OPND_SW);
      addr    = (kind == OPND_MVA) ? (data & line_mask) : '0;
      set_idx = (kind == OPND_SW) ? set_raw : '0;
      way_idx = (kind == OPND_SW) ? way_raw : '0;
   end

endmodule

// File: rtl/cmo_ctrl.sv
module cmo_ctrl
   import cmo_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int SET_W      = 6,
   parameter int WAY_WP     = 2,
   parameter int CLEAN_BIT  = 30,
   parameter int LINK_OFS   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  cmo_dec_t          dec,
   input  logic [DATA_W-1:0] req_pc,
   input  logic              in_sw,
   input  logic [DATA_W-1:0] in_addr,
   input  logic [SET_W-1:0]  in_set,
   input  logic [WAY_WP-1:0] in_way,
   input  logic              ic_done,
   input  logic              dc_done,
   input  logic              dc_all_clean,
   input  logic              wb_empty,
   input  logic              irq,
   input  logic              dbg_req,
   output logic              busy,
   output logic              undef_op,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              ic_cmd_valid,
   output logic [1:0]        ic_cmd_kind,
   output logic              dc_cmd_valid,
   output logic [2:0]        dc_cmd_kind,
   output logic              op_sw,
   output logic [DATA_W-1:0] op_addr,
   output logic [SET_W-1:0]  op_set,
   output logic [WAY_WP-1:0] op_way,
   output logic              wb_drain_req,
   output logic              lowpower_req,
   output logic              wake_valid,
   output logic [DATA_W-1:0] wake_link
);

   if (CLEAN_BIT < 0 || CLEAN_BIT >= DATA_W) begin : g_bad_bit
      $error("CLEAN_BIT outside the data word");
   end

   cmo_state_e state_q;
   logic       pend_ic_q, pend_dc_q;
   logic       read_q, wfi_q;
   logic [DATA_W-1:0] pc_q;
   logic       ic_left, dc_left;

   assign ic_left = pend_ic_q && !ic_done;
   assign dc_left = pend_dc_q && !dc_done;

   assign busy         = (state_q != ST_IDLE);
   assign wb_drain_req = (state_q == ST_DRAIN);
   assign lowpower_req = (state_q == ST_SLEEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         pend_ic_q    <= 1'b0;
         pend_dc_q    <= 1'b0;
         read_q       <= 1'b0;
         wfi_q        <= 1'b0;
         pc_q         <= '0;
         undef_op     <= 1'b0;
         rd_valid     <= 1'b0;
         rd_data      <= '0;
         ic_cmd_valid <= 1'b0;
         ic_cmd_kind  <= '0;
         dc_cmd_valid <= 1'b0;
         dc_cmd_kind  <= '0;
         op_sw        <= 1'b0;
         op_addr      <= '0;
         op_set       <= '0;
         op_way       <= '0;
         wake_valid   <= 1'b0;
         wake_link    <= '0;
      end else begin
         ic_cmd_valid <= 1'b0;
         dc_cmd_valid <= 1'b0;
         undef_op     <= 1'b0;
         rd_valid     <= 1'b0;
         wake_valid   <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (req_valid) begin
                  if (!dec.legal) begin
                     undef_op <= 1'b1;
                  end else begin
                     pc_q        <= req_pc;
                     read_q      <= dec.is_read;
                     ic_cmd_kind <= dec.ic_kind;
                     dc_cmd_kind <= dec.dc_kind;
                     op_sw       <= in_sw;
                     op_addr     <= in_addr;
                     op_set      <= in_set;
                     op_way      <= in_way;
                     if (dec.is_drain || dec.is_wfi) begin
                        wfi_q   <= dec.is_wfi;
                        state_q <= ST_DRAIN;
                     end else begin
                        ic_cmd_valid <= dec.use_ic;
                        dc_cmd_valid <= dec.use_dc;
                        pend_ic_q    <= dec.use_ic;
                        pend_dc_q    <= dec.use_dc;
                        state_q      <= ST_CACHE;
                     end
                  end
               end
            end
            ST_CACHE: begin
               if (ic_done) pend_ic_q <= 1'b0;
               if (dc_done) pend_dc_q <= 1'b0;
               if (!ic_left && !dc_left) begin
                  state_q <= ST_IDLE;
                  if (read_q) begin
                     rd_valid <= 1'b1;
                     rd_data  <= DATA_W'(dc_all_clean) << CLEAN_BIT;
                  end
               end
            end
            ST_DRAIN: begin
               if (wb_empty) state_q <= wfi_q ? ST_SLEEP : ST_IDLE;
            end
            ST_SLEEP: begin
               if (irq || dbg_req) begin
                  state_q <= ST_IDLE;
                  if (irq) begin
                     wake_valid <= 1'b1;
                     wake_link  <= pc_q + DATA_W'(LINK_OFS);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/cache_maint_sequencer.sv
module cache_maint_sequencer
   import cmo_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NUM_WAYS   = 4,
   parameter int LINE_BYTES = 32,
   parameter int NUM_SETS   = 64,
   parameter int CLEAN_BIT  = 30,
   localparam int SET_W     = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1,
   localparam int WAY_W     = $clog2(NUM_WAYS),
   localparam int WAY_WP    = (WAY_W > 0) ? WAY_W : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [3:0]        req_crm,
   input  logic [2:0]        req_op2,
   input  logic [DATA_W-1:0] req_data,
   input  logic [DATA_W-1:0] req_pc,
   output logic              busy,
   output logic              undef_op,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              ic_cmd_valid,
   output logic [1:0]        ic_cmd_kind,
   input  logic              ic_done,
   output logic              dc_cmd_valid,
   output logic [2:0]        dc_cmd_kind,
   input  logic              dc_done,
   input  logic              dc_all_clean,
   output logic              op_sw,
   output logic [DATA_W-1:0] op_addr,
   output logic [SET_W-1:0]  op_set,
   output logic [WAY_WP-1:0] op_way,
   output logic              wb_drain_req,
   input  logic              wb_empty,
   output logic              lowpower_req,
   input  logic              irq,
   input  logic              dbg_req,
   output logic              wake_valid,
   output logic [DATA_W-1:0] wake_link
);

   cmo_dec_t          dec;
   logic              n_sw;
   logic [DATA_W-1:0] n_addr;
   logic [SET_W-1:0]  n_set;
   logic [WAY_WP-1:0] n_way;

   cmo_decode u_decode (
      .write (req_write),
      .crm   (req_crm),
      .op2   (req_op2),
      .dec   (dec)
   );

   cmo_operand #(
      .DATA_W     (DATA_W),
      .NUM_WAYS   (NUM_WAYS),
      .LINE_BYTES (LINE_BYTES),
      .NUM_SETS   (NUM_SETS)
   ) u_operand (
      .data    (req_data),
      .kind    (dec.opnd),
      .sw      (n_sw),
      .addr    (n_addr),
      .set_idx (n_set),
      .way_idx (n_way)
   );

   cmo_ctrl #(
      .DATA_W    (DATA_W),
      .SET_W     (SET_W),
      .WAY_WP    (WAY_WP),
      .CLEAN_BIT (CLEAN_BIT),
      .LINK_OFS  (8)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .dec          (dec),
      .req_pc       (req_pc),
      .in_sw        (n_sw),
      .in_addr      (n_addr),
      .in_set       (n_set),
      .in_way       (n_way),
      .ic_done      (ic_done),
      .dc_done      (dc_done),
      .dc_all_clean (dc_all_clean),
      .wb_empty     (wb_empty),
      .irq          (irq),
      .dbg_req      (dbg_req),
      .busy         (busy),
      .undef_op     (undef_op),
      .rd_valid     (rd_valid),
      .rd_data      (rd_data),
      .ic_cmd_valid (ic_cmd_valid),
      .ic_cmd_kind  (ic_cmd_kind),
      .dc_cmd_valid (dc_cmd_valid),
      .dc_cmd_kind  (dc_cmd_kind),
      .op_sw        (op_sw),
      .op_addr      (op_addr),
      .op_set       (op_set),
      .op_way       (op_way),
      .wb_drain_req (wb_drain_req),
      .lowpower_req (lowpower_req),
      .wake_valid   (wake_valid),
      .wake_link    (wake_link)
   );

endmodule

// File: rtl/cmo_checker.sv
module cmo_checker #(
   parameter int DATA_W    = 32,
   parameter int CLEAN_BIT = 30
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              undef_op,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              ic_cmd_valid,
   input logic              dc_cmd_valid,
   input logic              wb_drain_req,
   input logic              wb_empty,
   input logic              lowpower_req,
   input logic              wake_valid
);

   localparam logic [DATA_W-1:0] FLAG_MASK = DATA_W'(1) << CLEAN_BIT;

   // R6: strobes are single-cycle
   a_r6_ic_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      ic_cmd_valid |=> !ic_cmd_valid);
   a_r6_dc_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      dc_cmd_valid |=> !dc_cmd_valid);
   // R6: a strobe only appears while the core is stalled
   a_r6_strobe_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (ic_cmd_valid || dc_cmd_valid) |-> busy);
   // R11: an undefined request leaves everything quiet
   a_r11_undef_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      undef_op |-> (!busy && !ic_cmd_valid && !dc_cmd_valid));
   // R9: sleep only after an empty write buffer was seen
   a_r9_sleep_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lowpower_req) |-> $past(wb_empty));
   a_r9_sleep_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      lowpower_req |-> (busy && !wb_drain_req));
   // R8: drain request holds the core
   a_r8_drain_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      wb_drain_req |-> busy);
   // R7: status word has only the clean flag
   a_r7_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ((rd_data & ~FLAG_MASK) == '0));
   // R10: a wake pulse ends the sleep state
   a_r10_wake_ends_sleep: assert property (@(posedge clk) disable iff (!rst_n)
      wake_valid |-> (!lowpower_req && $past(lowpower_req)));

endmodule

bind cache_maint_sequencer cmo_checker #(
   .DATA_W    (DATA_W),
   .CLEAN_BIT (CLEAN_BIT)
) u_cmo_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy         (busy),
   .undef_op     (undef_op),
   .rd_valid     (rd_valid),
   .rd_data      (rd_data),
   .ic_cmd_valid (ic_cmd_valid),
   .dc_cmd_valid (dc_cmd_valid),
   .wb_drain_req (wb_drain_req),
   .wb_empty     (wb_empty),
   .lowpower_req (lowpower_req),
   .wake_valid   (wake_valid)
);

// File: tb/tb_cache_maint_sequencer.sv
module tb_cache_maint_sequencer;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [3:0]  req_crm = '0;
   logic [2:0]  req_op2 = '0;
   logic [31:0] req_data = '0, req_pc = '0;
   logic        busy, undef_op, rd_valid, ic_cmd_valid, dc_cmd_valid;
   logic [31:0] rd_data, op_addr, wake_link;
   logic [1:0]  ic_cmd_kind;
   logic [2:0]  dc_cmd_kind;
   logic        ic_done = 1'b0, dc_done = 1'b0, dc_all_clean = 1'b0;
   logic        op_sw, wb_drain_req, lowpower_req, wake_valid;
   logic [5:0]  op_set;
   logic [1:0]  op_way;
   logic        wb_empty = 1'b1, irq = 1'b0, dbg_req = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cache_maint_sequencer dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_crm(req_crm), .req_op2(req_op2), .req_data(req_data), .req_pc(req_pc),
      .busy(busy), .undef_op(undef_op), .rd_valid(rd_valid), .rd_data(rd_data),
      .ic_cmd_valid(ic_cmd_valid), .ic_cmd_kind(ic_cmd_kind), .ic_done(ic_done),
      .dc_cmd_valid(dc_cmd_valid), .dc_cmd_kind(dc_cmd_kind), .dc_done(dc_done),
      .dc_all_clean(dc_all_clean), .op_sw(op_sw), .op_addr(op_addr), .op_set(op_set),
      .op_way(op_way), .wb_drain_req(wb_drain_req), .wb_empty(wb_empty),
      .lowpower_req(lowpower_req), .irq(irq), .dbg_req(dbg_req),
      .wake_valid(wake_valid), .wake_link(wake_link));

   typedef enum int {EV_IC, EV_DC, EV_RD, EV_WAKE, EV_UNDEF} ev_e;
   typedef struct {
      ev_e         typ;
      int          kind;
      logic        sw;
      logic [31:0] val;
      string       req;
   } item_t;

   item_t exp_q[$];
   int n_chk = 0, n_fail = 0;
   int ic_lat = 1, dc_lat = 1, ic_cnt = 0, dc_cnt = 0;
   bit finished = 0;

   task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic expect_ev(ev_e t, int k, logic s, logic [31:0] v, string r);
      item_t it;
      it.typ = t; it.kind = k; it.sw = s; it.val = v; it.req = r;
      exp_q.push_back(it);
   endtask

   function automatic logic [31:0] sw_val(int way, int set);
      return {16'(way), 16'(set)};
   endfunction

   task automatic observe(ev_e t, int k, logic s, logic [31:0] v);
      item_t it;
      if (exp_q.size() == 0) begin
         check(0, "R6", $sformatf("unexpected event type %0d kind %0d", t, k), v, 32'h0);
      end else begin
         it = exp_q.pop_front();
         check(it.typ == t && it.kind == k && it.sw == s && it.val == v, it.req,
               $sformatf("event type %0d/%0d kind %0d/%0d sw %0b/%0b", t, it.typ, k, it.kind, s, it.sw),
               v, it.val);
      end
   endtask

   // monitor: scoreboard side
   always @(negedge clk) begin
      if (rst_n) begin
         if (ic_cmd_valid) observe(EV_IC, int'(ic_cmd_kind), op_sw, op_sw ? sw_val(op_way, op_set) : op_addr);
         if (dc_cmd_valid) observe(EV_DC, int'(dc_cmd_kind), op_sw, op_sw ? sw_val(op_way, op_set) : op_addr);
         if (rd_valid)     observe(EV_RD, 0, 1'b0, rd_data);
         if (wake_valid)   observe(EV_WAKE, 0, 1'b0, wake_link);
         if (undef_op)     observe(EV_UNDEF, 0, 1'b0, 32'h0);
      end
   end

   // cache models: done pulse after a programmable latency
   always @(negedge clk) begin
      ic_done = 1'b0;
      if (ic_cmd_valid) begin
         if (ic_lat == 0) ic_done = 1'b1; else ic_cnt = ic_lat;
      end else if (ic_cnt > 0) begin
         ic_cnt--;
         if (ic_cnt == 0) ic_done = 1'b1;
      end
   end
   always @(negedge clk) begin
      dc_done = 1'b0;
      if (dc_cmd_valid) begin
         if (dc_lat == 0) dc_done = 1'b1; else dc_cnt = dc_lat;
      end else if (dc_cnt > 0) begin
         dc_cnt--;
         if (dc_cnt == 0) dc_done = 1'b1;
      end
   end

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send(bit wr, int crm, int op2, logic [31:0] d, logic [31:0] pc);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_crm = crm[3:0]; req_op2 = op2[2:0];
      req_data = d; req_pc = pc;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_idle(string req);
      for (int g = 0; g < 200 && busy; g++) @(negedge clk);
      @(negedge clk);
      check(exp_q.size() == 0, req, "events still expected", exp_q.size(), 0);
   endtask

   task automatic cache_op(bit wr, int crm, int op2, logic [31:0] d, string req);
      send(wr, crm, op2, d, 32'h0);
      wait_idle(req);
   endtask

   initial begin
      cycles(3);
      // R1: reset state
      check(!busy && !ic_cmd_valid && !dc_cmd_valid && !wb_drain_req && !lowpower_req
            && !rd_valid && !wake_valid && !undef_op, "R1", "outputs in reset", busy, 0);
      rst_n = 1'b1;
      cycles(2);
      check(!busy && !lowpower_req && !wb_drain_req, "R1", "outputs after reset", busy, 0);

      // R2: both caches, dc finishes first then ic finishes first
      ic_lat = 4; dc_lat = 1;
      expect_ev(EV_IC, 0, 0, 0, "R2"); expect_ev(EV_DC, 0, 0, 0, "R2");
      send(1, 7, 0, 32'hDEAD_0000, 0);
      check(busy, "R6", "busy after accept", busy, 1);
      cycles(3);
      check(busy, "R2", "busy while ic pending", busy, 1);
      wait_idle("R2");
      ic_lat = 0; dc_lat = 4;
      expect_ev(EV_IC, 0, 0, 0, "R2"); expect_ev(EV_DC, 0, 0, 0, "R2");
      send(1, 7, 0, 0, 0);
      cycles(2);
      check(busy, "R2", "busy while dc pending", busy, 1);
      wait_idle("R2");
      ic_lat = 1; dc_lat = 1;

      // R3: instruction-cache ops; R5 operand shaping
      expect_ev(EV_IC, 0, 0, 0, "R3");             cache_op(1, 5, 0, 0, "R3");
      expect_ev(EV_IC, 1, 0, 32'h1234_5660, "R5"); cache_op(1, 5, 1, 32'h1234_567F, "R5");
      expect_ev(EV_IC, 2, 1, sw_val(3, 10), "R5"); cache_op(1, 5, 2, 32'hC000_0140, "R5");
      expect_ev(EV_IC, 3, 0, 32'h8000_0020, "R3"); cache_op(1, 13, 1, 32'h8000_003F, "R3");

      // R4: data-cache ops
      expect_ev(EV_DC, 0, 0, 0, "R4");             cache_op(1, 6, 0, 0, "R4");
      expect_ev(EV_DC, 1, 0, 32'h0000_1000, "R4"); cache_op(1, 6, 1, 32'h0000_101C, "R4");
      expect_ev(EV_DC, 1, 1, sw_val(1, 63), "R4"); cache_op(1, 6, 2, 32'h4000_07E0, "R4");
      expect_ev(EV_DC, 2, 0, 32'hFFFF_FFE0, "R4"); cache_op(1, 10, 1, 32'hFFFF_FFFF, "R4");
      expect_ev(EV_DC, 2, 1, sw_val(2, 1), "R4");  cache_op(1, 10, 2, 32'h8000_0020, "R4");
      expect_ev(EV_DC, 3, 0, 32'h0ABC_DE00, "R4"); cache_op(1, 14, 1, 32'h0ABC_DE04, "R4");
      expect_ev(EV_DC, 3, 1, sw_val(0, 5), "R4");  cache_op(1, 14, 2, 32'h0000_00A0, "R4");
      // R5: bits outside the set/way fields have no effect
      expect_ev(EV_DC, 1, 1, sw_val(3, 63), "R5"); cache_op(1, 6, 2, 32'hFFFF_FFFF, "R5");
      expect_ev(EV_DC, 1, 1, sw_val(0, 0), "R5");  cache_op(1, 6, 2, 32'h3FFF_F81F, "R5");

      // R6: one-cycle strobe, request while busy ignored
      dc_lat = 6;
      expect_ev(EV_DC, 1, 0, 32'h0000_2000, "R6");
      send(1, 6, 1, 32'h0000_2000, 0);
      check(dc_cmd_valid, "R6", "strobe in first busy cycle", dc_cmd_valid, 1);
      send(1, 5, 0, 0, 0);
      check(!dc_cmd_valid && !ic_cmd_valid && busy, "R6", "no strobe for request while busy",
            {dc_cmd_valid, ic_cmd_valid}, 0);
      wait_idle("R6");
      check(!busy, "R6", "busy released", busy, 0);
      dc_lat = 2;

      // R7: test-and-clean reads
      dc_all_clean = 1'b1;
      expect_ev(EV_DC, 4, 0, 0, "R7"); expect_ev(EV_RD, 0, 0, 32'h4000_0000, "R7");
      cache_op(0, 10, 3, 32'h1111_1111, "R7");
      dc_all_clean = 1'b0;
      expect_ev(EV_DC, 5, 0, 0, "R7"); expect_ev(EV_RD, 0, 0, 32'h0, "R7");
      cache_op(0, 14, 3, 0, "R7");
      dc_lat = 1;

      // R8: write-buffer drain barrier
      wb_empty = 1'b0;
      send(1, 10, 4, 0, 0);
      cycles(4);
      check(busy && wb_drain_req && !lowpower_req, "R8", "drain holds core",
            {busy, wb_drain_req, lowpower_req}, 3'b110);
      wb_empty = 1'b1;
      cycles(1);
      check(!busy && !wb_drain_req, "R8", "drain completes", {busy, wb_drain_req}, 0);
      wait_idle("R8");

      // R9 / R10: sleep woken by interrupt
      wb_empty = 1'b0;
      send(1, 0, 4, 0, 32'h0000_1000);
      cycles(3);
      check(wb_drain_req && !lowpower_req, "R9", "drain before sleep",
            {wb_drain_req, lowpower_req}, 2'b10);
      wb_empty = 1'b1;
      cycles(1);
      check(lowpower_req && busy, "R9", "low power after drain", {lowpower_req, busy}, 2'b11);
      cycles(5);
      check(lowpower_req && busy, "R9", "sleep held without wake", {lowpower_req, busy}, 2'b11);
      expect_ev(EV_WAKE, 0, 0, 32'h0000_1008, "R10");
      irq = 1'b1;
      cycles(1);
      irq = 1'b0;
      check(!busy && !lowpower_req, "R10", "interrupt wakes", {busy, lowpower_req}, 0);
      wait_idle("R10");

      // R10: debug wake, no link
      send(1, 0, 4, 0, 32'h0000_2000);
      cycles(2);
      check(lowpower_req, "R9", "sleep entered with empty buffer", lowpower_req, 1);
      dbg_req = 1'b1;
      cycles(1);
      dbg_req = 1'b0;
      check(!busy && !lowpower_req, "R10", "debug wakes", {busy, lowpower_req}, 0);
      wait_idle("R10");

      // R11: undefined encodings
      expect_ev(EV_UNDEF, 0, 0, 0, "R11"); cache_op(1, 3, 0, 0, "R11");
      expect_ev(EV_UNDEF, 0, 0, 0, "R11"); cache_op(0, 7, 0, 0, "R11");
      expect_ev(EV_UNDEF, 0, 0, 0, "R11"); cache_op(1, 10, 3, 0, "R11");
      expect_ev(EV_UNDEF, 0, 0, 0, "R11"); cache_op(1, 5, 3, 0, "R11");
      expect_ev(EV_UNDEF, 0, 0, 0, "R11"); send(0, 0, 4, 0, 0);
      check(!busy && !lowpower_req && !wb_drain_req, "R11", "undefined leaves idle",
            {busy, lowpower_req, wb_drain_req}, 0);
      wait_idle("R11");

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule